// File: doc/BRIEF.md
# Nonvolatile Transfer Sequencer

This block sits between a host's byte-wide access strobes and a volatile array whose every cell has a nonvolatile shadow. It decides when the contents move between the two copies and keeps the host off the array while they do. A save (volatile to shadow) can be started by an external request pin, by a software pulse, or by a falling supply flag. A restore (shadow to volatile) can be started by reset, by the return of the supply, or by a software pulse.

A save runs as an erase phase followed by a program phase. A restore runs as a clear phase followed by a copy phase. Each phase lasts a fixed number of clock cycles set by a parameter. The current phase is presented on `phase_o` for the array model, and a one-cycle done pulse marks the end of each kind of transfer. The request pin is wired-AND: the block pulls it low while a save runs, and it samples the pin level through a two-stage synchronizer.

A dirty flag records whether any write has been granted since the last completed transfer. Saves started by the pin or by power loss need that flag. Software saves do not. When the pin request arrives, a guard window lets accesses that are already in flight finish before the erase begins.

Top module: `nvx_seq_ctrl`

## Requirements
- R1: A `sw_store` pulse in the idle phase starts a save whether or not the array is dirty. The save is an erase phase of ERASE_CYC cycles, then a program phase of PROG_CYC cycles, and ends with one cycle of `store_done_o`.
- R2: A low request pin, or a low `supply_ok`, starts no save unless a write was granted since the most recent completed save or restore.
- R3: When the synchronized request pin is low and the array is dirty, a guard phase of GUARD_CYC cycles runs before the erase. During the guard phase reads are granted, and a write that was already granted before the pin fell keeps being granted while write mode is held.
- R4: A write whose write mode begins while the synchronized request pin is low is not granted.
- R5: `hs_drive_low_o` is high exactly in the erase and program phases. After a save, the block stays in the hold phase (no access granted) until the synchronized pin is seen high.
- R6: A `sw_recall` pulse in the idle phase starts a restore. The restore is a clear phase of CLEAR_CYC cycles, then a copy phase of COPY_CYC cycles, and ends with one cycle of `recall_done_o`.
- R7: A low `supply_ok` latches a pending restore, and reset also leaves one pending. The pending restore starts from idle once `supply_ok` is high.
- R8: A low `supply_ok` starts a save only while automatic save is enabled. It is enabled after reset, `auto_off` disables it and `auto_on` re-enables it. While `supply_ok` is low, no write is granted and `sw_store` and the request pin start nothing.
- R9: If write mode is present in the cycle a transfer completes, that write is not granted until write mode has been released and asserted again.
- R10: In the idle and guard phases, read mode (`sel_n`=0, `wen_n`=1) drives `arr_rd_en` and write mode (`sel_n`=0, `wen_n`=0) drives `arr_wr_en`. In every other phase both enables are low.
- R11: `phase_o` encodes idle=0, guard=1, erase=2, program=3, clear=4, copy=5, hold=6. Reset gives idle with the pin released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Host select, active low |
| wen_n | input | 1 | Host write enable, active low |
| hs_pin_i | input | 1 | Level of the wired-AND request/busy pin |
| hs_drive_low_o | output | 1 | Pull the request/busy pin low |
| supply_ok | input | 1 | High while the supply is above its threshold |
| sw_store | input | 1 | Software save pulse |
| sw_recall | input | 1 | Software restore pulse |
| auto_on | input | 1 | Enable save on power loss |
| auto_off | input | 1 | Disable save on power loss |
| arr_rd_en | output | 1 | Read enable to the volatile array |
| arr_wr_en | output | 1 | Write enable to the volatile array |
| phase_o | output | 3 | Current transfer phase |
| store_done_o | output | 1 | One-cycle save completion pulse |
| recall_done_o | output | 1 | One-cycle restore completion pulse |

## Verification
The assertions assume the following about the inputs:
- The host strobes, software pulses and `supply_ok` are synchronous to `clk`.
- Each software pulse lasts a single cycle.
- The pin level is the AND of the block's own pull-down and any external pull-down.

The bench models the pin exactly that way. It changes every input only at the falling edge or just after a rising edge. It raises each software command for one cycle and never holds two of them high together. Phase durations are measured by counting sampled phases over fixed windows that are longer than any transfer.

// File: rtl/nvx_pkg.sv
`timescale 1ns/1ps
package nvx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_GUARD = 3'd1,
        PH_ERASE = 3'd2,
        PH_PROG  = 3'd3,
        PH_CLEAR = 3'd4,
        PH_COPY  = 3'd5,
        PH_HOLD  = 3'd6
    } nvx_phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } nvx_host_t;

    function automatic nvx_host_t decode_host(logic sel_n, logic wen_n);
        nvx_host_t h;
        h.rd = !sel_n && wen_n;
        h.wr = !sel_n && !wen_n;
        return h;
    endfunction

    function automatic logic phase_open(nvx_phase_e p);
        return (p == PH_IDLE) || (p == PH_GUARD);
    endfunction

    function automatic logic phase_saving(nvx_phase_e p);
        return (p == PH_ERASE) || (p == PH_PROG);
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvx_sync2.sv
`timescale 1ns/1ps
module nvx_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RST_VAL;
            q  <= RST_VAL;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/nvx_phase_fsm.sv
`timescale 1ns/1ps
module nvx_phase_fsm
    import nvx_pkg::*;
#(
    parameter int unsigned GUARD_CYC = 8,
    parameter int unsigned ERASE_CYC = 6,
    parameter int unsigned PROG_CYC  = 10,
    parameter int unsigned CLEAR_CYC = 4,
    parameter int unsigned COPY_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hs_sync,
    input  logic       supply_ok,
    input  logic       sw_store,
    input  logic       sw_recall,
    input  logic       auto_on,
    input  logic       auto_off,
    input  logic       dirty,
    output nvx_phase_e phase,
    output logic       drive_low,
    output logic       store_done,
    output logic       recall_done
);
    localparam int unsigned MAXC = max_of(max_of(max_of(GUARD_CYC, ERASE_CYC),
                                                 max_of(PROG_CYC, CLEAR_CYC)), COPY_CYC);
    localparam int unsigned CW = (MAXC < 2) ? 1 : $clog2(MAXC);

    nvx_phase_e   state, nxt;
    logic [CW-1:0] cnt;
    logic          auto_en_q;
    logic          rcl_pend_q;
    logic          dirty_eff;

    function automatic logic [CW-1:0] span(nvx_phase_e p);
        case (p)
            PH_GUARD: span = CW'(GUARD_CYC - 1);
            PH_ERASE: span = CW'(ERASE_CYC - 1);
            PH_PROG:  span = CW'(PROG_CYC - 1);
            PH_CLEAR: span = CW'(CLEAR_CYC - 1);
            PH_COPY:  span = CW'(COPY_CYC - 1);
            default:  span = '0;
        endcase
    endfunction

    // the dirty flag clears one edge after a restore finishes; mask it meanwhile
    assign dirty_eff = dirty && !recall_done;

    always_comb begin
        nxt = state;
        case (state)
            PH_IDLE: begin
                if (!supply_ok) begin
                    if (auto_en_q && dirty_eff) nxt = PH_ERASE;
                end else if (rcl_pend_q) begin
                    nxt = PH_CLEAR;
                end else if (sw_recall) begin
                    nxt = PH_CLEAR;
                end else if (sw_store) begin
                    nxt = PH_ERASE;
                end else if (!hs_sync && dirty_eff) begin
                    nxt = PH_GUARD;
                end
            end
            PH_GUARD: if (cnt == '0) nxt = PH_ERASE;
            PH_ERASE: if (cnt == '0) nxt = PH_PROG;
            PH_PROG:  if (cnt == '0) nxt = PH_HOLD;
            PH_CLEAR: if (cnt == '0) nxt = PH_COPY;
            PH_COPY:  if (cnt == '0) nxt = PH_IDLE;
            PH_HOLD:  if (hs_sync)   nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PH_IDLE;
            cnt         <= '0;
            store_done  <= 1'b0;
            recall_done <= 1'b0;
        end else begin
            state       <= nxt;
            store_done  <= (state == PH_PROG) && (cnt == '0);
            recall_done <= (state == PH_COPY) && (cnt == '0);
            if (nxt != state)   cnt <= span(nxt);
            else if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           auto_en_q <= 1'b1;
        else if (auto_on)  auto_en_q <= 1'b1;
        else if (auto_off) auto_en_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                                       rcl_pend_q <= 1'b1;
        else if (!supply_ok)                           rcl_pend_q <= 1'b1;
        else if (state == PH_IDLE && nxt == PH_CLEAR)  rcl_pend_q <= 1'b0;
    end

    assign phase     = state;
    assign drive_low = phase_saving(state);
endmodule

// File: rtl/nvx_access_gate.sv
`timescale 1ns/1ps
module nvx_access_gate
    import nvx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       wen_n,
    input  nvx_phase_e phase,
    input  logic       hs_sync,
    input  logic       supply_ok,
    input  logic       xfer_done,
    output logic       rd_en,
    output logic       wr_en,
    output logic       dirty
);
    nvx_host_t host;
    logic      open_now;
    logic      suppress_q;
    logic      granted_q;
    logic      pin_ok;

    assign host     = decode_host(sel_n, wen_n);
    assign open_now = phase_open(phase);

    // a write granted before the pin fell may carry on while it is held
    assign pin_ok = hs_sync || (granted_q && host.wr);

    assign rd_en = open_now && host.rd;
    assign wr_en = open_now && host.wr && supply_ok && pin_ok
                   && !suppress_q && !xfer_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            suppress_q <= 1'b0;
            granted_q  <= 1'b0;
            dirty      <= 1'b0;
        end else begin
            granted_q <= wr_en;
            if (xfer_done && host.wr) suppress_q <= 1'b1;
            else if (!host.wr)        suppress_q <= 1'b0;
            if (xfer_done)  dirty <= 1'b0;
            else if (wr_en) dirty <= 1'b1;
        end
    end
endmodule

// File: rtl/nvx_seq_ctrl.sv
`timescale 1ns/1ps
module nvx_seq_ctrl
    import nvx_pkg::*;
#(
    parameter int unsigned GUARD_CYC = 8,
    parameter int unsigned ERASE_CYC = 6,
    parameter int unsigned PROG_CYC  = 10,
    parameter int unsigned CLEAR_CYC = 4,
    parameter int unsigned COPY_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       wen_n,
    input  logic       hs_pin_i,
    output logic       hs_drive_low_o,
    input  logic       supply_ok,
    input  logic       sw_store,
    input  logic       sw_recall,
    input  logic       auto_on,
    input  logic       auto_off,
    output logic       arr_rd_en,
    output logic       arr_wr_en,
    output logic [2:0] phase_o,
    output logic       store_done_o,
    output logic       recall_done_o
);
    logic       hs_sync;
    logic       dirty;
    nvx_phase_e phase;

    nvx_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hs_pin_i),
        .q   (hs_sync)
    );

    nvx_phase_fsm #(
        .GUARD_CYC (GUARD_CYC),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC),
        .CLEAR_CYC (CLEAR_CYC),
        .COPY_CYC  (COPY_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .hs_sync     (hs_sync),
        .supply_ok   (supply_ok),
        .sw_store    (sw_store),
        .sw_recall   (sw_recall),
        .auto_on     (auto_on),
        .auto_off    (auto_off),
        .dirty       (dirty),
        .phase       (phase),
        .drive_low   (hs_drive_low_o),
        .store_done  (store_done_o),
        .recall_done (recall_done_o)
    );

    nvx_access_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .sel_n     (sel_n),
        .wen_n     (wen_n),
        .phase     (phase),
        .hs_sync   (hs_sync),
        .supply_ok (supply_ok),
        .xfer_done (store_done_o || recall_done_o),
        .rd_en     (arr_rd_en),
        .wr_en     (arr_wr_en),
        .dirty     (dirty)
    );

    assign phase_o = phase;
endmodule

// File: rtl/nvx_seq_chk.sv
`timescale 1ns/1ps
module nvx_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       hs_drive_low_o,
    input logic       arr_rd_en,
    input logic       arr_wr_en,
    input logic [2:0] phase_o,
    input logic       store_done_o,
    input logic       recall_done_o
);
    // R10
    xfer_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o >= 3'd2) |-> !(arr_rd_en || arr_wr_en));

    // R1
    store_done_src_chk: assert property (@(posedge clk) disable iff (rst)
        store_done_o |-> ($past(phase_o) == 3'd3));

    // R6
    recall_done_src_chk: assert property (@(posedge clk) disable iff (rst)
        recall_done_o |-> ($past(phase_o) == 3'd5));

    // R8
    lowsupply_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> !arr_wr_en);

    // R5
    drive_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_drive_low_o) |-> (phase_o == 3'd2));

    // R1
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_done_o, recall_done_o}));
endmodule

bind nvx_seq_ctrl nvx_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .supply_ok      (supply_ok),
    .hs_drive_low_o (hs_drive_low_o),
    .arr_rd_en      (arr_rd_en),
    .arr_wr_en      (arr_wr_en),
    .phase_o        (phase_o),
    .store_done_o   (store_done_o),
    .recall_done_o  (recall_done_o)
);

// File: tb/tb_nvx_seq_ctrl.sv
`timescale 1ns/1ps
module tb_nvx_seq_ctrl;
    localparam int GUARD = 8, ERASE = 6, PROG = 10, CLEAR = 4, COPY = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, wen_n = 1'b1, ext_low = 1'b0, supply_ok = 1'b1;
    logic sw_store = 1'b0, sw_recall = 1'b0, auto_on = 1'b0, auto_off = 1'b0;
    logic hs_pin, hs_drive_low_o, arr_rd_en, arr_wr_en, store_done_o, recall_done_o;
    logic [2:0] phase_o;

    int n_checks = 0, n_fail = 0;
    int t_guard, t_erase, t_prog, t_clear, t_copy, t_sdone, t_rdone;
    int t_xacc, t_drv, t_drv_out, t_rdg;

    always #2.5 clk = ~clk;
    assign hs_pin = !(ext_low || hs_drive_low_o);

    nvx_seq_ctrl #(.GUARD_CYC(GUARD), .ERASE_CYC(ERASE), .PROG_CYC(PROG),
                   .CLEAR_CYC(CLEAR), .COPY_CYC(COPY)) dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wen_n(wen_n), .hs_pin_i(hs_pin),
        .hs_drive_low_o(hs_drive_low_o), .supply_ok(supply_ok), .sw_store(sw_store),
        .sw_recall(sw_recall), .auto_on(auto_on), .auto_off(auto_off),
        .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en), .phase_o(phase_o),
        .store_done_o(store_done_o), .recall_done_o(recall_done_o));

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sample();
        @(posedge clk); #1;
    endtask

    // watch n cycles, tally phases and events; software pulses drop after the first edge
    task automatic tally(input int n);
        t_guard = 0; t_erase = 0; t_prog = 0; t_clear = 0; t_copy = 0;
        t_sdone = 0; t_rdone = 0; t_xacc = 0; t_drv = 0; t_drv_out = 0; t_rdg = 0;
        for (int i = 0; i < n; i++) begin
            sample();
            case (phase_o)
                3'd1: t_guard++;
                3'd2: t_erase++;
                3'd3: t_prog++;
                3'd4: t_clear++;
                3'd5: t_copy++;
                default: ;
            endcase
            if (store_done_o) t_sdone++;
            if (recall_done_o) t_rdone++;
            if ((arr_rd_en || arr_wr_en) && phase_o >= 3'd2) t_xacc++;
            if (hs_drive_low_o) t_drv++;
            if (hs_drive_low_o && !(phase_o == 3'd2 || phase_o == 3'd3)) t_drv_out++;
            if (arr_rd_en && phase_o == 3'd1) t_rdg++;
            if (i == 0) begin
                sw_store = 0; sw_recall = 0;
            end
        end
    endtask

    task automatic pulse_auto(input logic on);
        @(negedge clk);
        if (on) auto_on = 1; else auto_off = 1;
        @(negedge clk);
        auto_on = 0; auto_off = 0;
    endtask

    task automatic one_write();
        @(negedge clk); sel_n = 0; wen_n = 0;
        sample();
        chk("R10 single write granted", arr_wr_en, 1);
        @(negedge clk); sel_n = 1; wen_n = 1;
    endtask

    task automatic t_reset_recall();
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset phase", phase_o, 0);
        chk("R11 reset pin released", hs_drive_low_o, 0);
        @(negedge clk); rst = 0;
        tally(30);
        chk("R7 power-up clear cycles", t_clear, CLEAR);
        chk("R7 power-up copy cycles", t_copy, COPY);
        chk("R6 restore done pulse", t_rdone, 1);
        chk("R11 idle after restore", phase_o, 0);
    endtask

    task automatic t_hw_clean();
        @(negedge clk); ext_low = 1;
        tally(20);
        chk("R2 clean pin request no guard", t_guard, 0);
        chk("R2 clean pin request no erase", t_erase, 0);
        chk("R2 clean pin request no drive", t_drv, 0);
        @(negedge clk); ext_low = 0;
        tally(4);
    endtask

    task automatic t_sw_store_clean();
        @(negedge clk); sel_n = 0; wen_n = 1; sw_store = 1;
        tally(40);
        chk("R1 erase cycles", t_erase, ERASE);
        chk("R1 program cycles", t_prog, PROG);
        chk("R1 save done pulse", t_sdone, 1);
        chk("R10 no access in transfer", t_xacc, 0);
        chk("R5 drive cycles", t_drv, ERASE + PROG);
        chk("R5 drive outside save", t_drv_out, 0);
        chk("R11 idle after save", phase_o, 0);
        @(negedge clk); sel_n = 1;
    endtask

    task automatic t_idle_access();
        @(negedge clk); sel_n = 0; wen_n = 1;
        sample();
        chk("R10 idle read rd_en", arr_rd_en, 1);
        chk("R10 idle read wr_en", arr_wr_en, 0);
        @(negedge clk); wen_n = 0;
        sample();
        chk("R10 idle write wr_en", arr_wr_en, 1);
        chk("R10 idle write rd_en", arr_rd_en, 0);
        @(negedge clk); sel_n = 1; wen_n = 1;
    endtask

    task automatic t_hw_dirty();
        @(negedge clk); ext_low = 1; sel_n = 0; wen_n = 1;
        tally(40);
        chk("R3 guard cycles", t_guard, GUARD);
        chk("R3 reads in guard", t_rdg, GUARD);
        chk("R1 erase after guard", t_erase, ERASE);
        chk("R1 program after guard", t_prog, PROG);
        chk("R5 drive during pin save", t_drv, ERASE + PROG);
        chk("R5 hold while pin low", phase_o, 6);
        chk("R5 no read in hold", arr_rd_en, 0);
        @(negedge clk); wen_n = 0;
        sample();
        chk("R5 no write in hold", arr_wr_en, 0);
        @(negedge clk); sel_n = 1; wen_n = 1; ext_low = 0;
        tally(6);
        chk("R5 idle once pin high", phase_o, 0);
    endtask

    task automatic t_inflight();
        @(negedge clk); sel_n = 0; wen_n = 0;
        @(negedge clk); ext_low = 1;
        repeat (5) @(posedge clk);
        #1;
        chk("R3 guard entered", phase_o, 1);
        chk("R3 in-flight write kept", arr_wr_en, 1);
        @(negedge clk); wen_n = 1;
        @(negedge clk); wen_n = 0;
        sample();
        chk("R4 new write blocked", arr_wr_en, 0);
        chk("R4 still guarding", phase_o, 1);
        @(negedge clk); sel_n = 1; wen_n = 1;
        tally(40);
        chk("R3 save after in-flight write", t_sdone, 1);
        @(negedge clk); ext_low = 0;
        tally(6);
    endtask

    task automatic t_sw_recall_suppress();
        @(negedge clk); sel_n = 0; wen_n = 0; sw_recall = 1;
        tally(30);
        chk("R6 clear cycles", t_clear, CLEAR);
        chk("R6 copy cycles", t_copy, COPY);
        chk("R6 restore done", t_rdone, 1);
        chk("R10 no access in restore", t_xacc, 0);
        chk("R9 held write suppressed", arr_wr_en, 0);
        @(negedge clk); wen_n = 1;
        @(negedge clk); wen_n = 0;
        sample();
        chk("R9 fresh write granted", arr_wr_en, 1);
        @(negedge clk); sel_n = 1; wen_n = 1;
    endtask

    task automatic t_powerfail();
        @(negedge clk); supply_ok = 0;
        tally(40);
        chk("R8 power-loss erase", t_erase, ERASE);
        chk("R8 power-loss program", t_prog, PROG);
        chk("R8 power-loss done", t_sdone, 1);
        @(negedge clk); sel_n = 0; wen_n = 0;
        sample();
        chk("R8 write blocked low supply", arr_wr_en, 0);
        @(negedge clk); sel_n = 1; wen_n = 1; sw_store = 1;
        tally(30);
        chk("R8 sw save ignored low supply", t_erase, 0);
        @(negedge clk); supply_ok = 1;
        tally(30);
        chk("R7 restore on supply return", t_clear, CLEAR);
        chk("R7 restore done", t_rdone, 1);
    endtask

    task automatic t_powerfail_clean();
        @(negedge clk); supply_ok = 0;
        tally(20);
        chk("R2 clean power loss no erase", t_erase, 0);
        @(negedge clk); supply_ok = 1;
        tally(30);
        chk("R7 restore after clean loss", t_rdone, 1);
    endtask

    task automatic t_auto_toggle();
        pulse_auto(1'b0);
        one_write();
        @(negedge clk); supply_ok = 0;
        tally(30);
        chk("R8 disabled no erase", t_erase, 0);
        @(negedge clk); supply_ok = 1;
        tally(30);
        chk("R7 restore with auto off", t_rdone, 1);
        pulse_auto(1'b1);
        one_write();
        @(negedge clk); supply_ok = 0;
        tally(40);
        chk("R8 re-enabled erase", t_erase, ERASE);
        @(negedge clk); supply_ok = 1;
        tally(30);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset_recall();
        t_hw_clean();
        t_sw_store_clean();
        t_idle_access();
        t_hw_dirty();
        t_inflight();
        t_sw_recall_suppress();
        t_powerfail();
        t_powerfail_clean();
        t_auto_toggle();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule